// File: doc/BRIEF.md
# Scrolling Tile-Map Address Generator

This block serves one background plane of a tile-based video renderer. For a column pair on the current scan line it works out the video-memory byte addresses of the two consecutive name-table entries the renderer must fetch. It takes into account the plane's table base, its configured width and height, the plane's horizontal scroll and a vertical scroll value. The vertical scroll value comes either from one shared entry or from a per-column entry of a vertical scroll RAM. The block also reports the fine vertical offset, which is the pixel row inside the tile.

When the two 16-bit entries come back from memory, a second step turns each one into the byte address of the 4-byte pattern row to fetch. That address honours the vertical-flip bit. The same step decodes the palette/priority tag. It also produces a pixel-order map that tells the compositor which nibble feeds each of the 8 output pixels, so horizontal flip is handled without moving any data.

Top module: `tilemap_addr_gen`

## Requirements
- R1: After reset, nt_valid and pat_valid are 0 and every address, fine_row, tag and order output is 0.
- R2: Bits 15:13 of both name-table addresses equal plane_reg bits 5:3, so the table base is (plane_reg & 0x38) << 10.
- R3: The vertical position is (vertical scroll + line_num) masked by a value chosen by size_reg bits 5:4: code 0 gives 0xFF, 1 gives 0x1FF, 2 gives 0 and 3 gives 0x3FF.
- R4: When mode_reg bit 2 is 1, the vertical scroll value is entry `column` of vscroll_ram, where entry k occupies bits [10k+9:10k]. When the bit is 0, entry 0 is used.
- R5: fine_row is the low 3 bits of the masked vertical position, and the tile row is that position divided by 8.
- R6: size_reg bits 1:0 choose a horizontal mask and a row stride: code 0 gives 0xF8 and 64, 1 gives 0x1F8 and 128, 2 gives 0 and 0, 3 gives 0x3F8 and 256. Each address is base + ((tile_row*stride + hpos/4) & 0x1FFF).
- R7: nt_addr0 uses hpos = (hscroll + (column-1)*8) & mask, computed modulo 1024 so that column 0 wraps. nt_addr1 uses hpos = (hscroll + column*8) & mask.
- R8: The name-table outputs and fine_row update on the clock edge at which req_valid is 1, and nt_valid is 1 for exactly that following cycle. At all other times the outputs hold their values.
- R9: The pattern address is (entry & 0x3FF) << 5 plus 4*f, where f is fine_row at the time of ent_valid. When entry bit 12 (vertical flip) is 1, it is 4*(7-f) instead.
- R10: Field p of order0/order1 (bits [3p+2:3p], p = 0..7 left to right) names the source nibble s: byte s/2 of the row, with the high nibble taken when s is even. Without a flip s = p. With entry bit 11 (horizontal flip) set, s = 7-p.
- R11: tag0/tag1 equal (entry >> 9) & 0x70. This places the priority bit (entry bit 15) at bit 6 and the palette (entry bits 14:13) at bits 5:4, and leaves all other tag bits 0.
- R12: The pattern outputs update on the clock edge at which ent_valid is 1, with pat_valid 1 for exactly that following cycle. At all other times the pattern outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an address computation for the column pair |
| column | input | 6 | Column number; also the per-column vertical scroll index |
| line_num | input | 10 | Current line number |
| plane_reg | input | 8 | Plane base register; bits 5:3 select the table base |
| size_reg | input | 8 | Plane size register; bits 5:4 set height, bits 1:0 set width |
| mode_reg | input | 8 | Mode register; bit 2 selects per-column vertical scroll |
| hscroll | input | 10 | Horizontal scroll of this plane |
| vscroll_ram | input | 640 | 64 vertical scroll entries of 10 bits each |
| nt_valid | output | 1 | Name-table addresses updated |
| nt_addr0 | output | 16 | Byte address of the first entry (column-1) |
| nt_addr1 | output | 16 | Byte address of the second entry (column) |
| fine_row | output | 3 | Pixel row inside the tile |
| ent_valid | input | 1 | Both fetched entries are present |
| entry0 | input | 16 | First fetched name-table entry |
| entry1 | input | 16 | Second fetched name-table entry |
| pat_valid | output | 1 | Pattern outputs updated |
| pat_addr0 | output | 16 | Pattern row byte address for entry0 |
| pat_addr1 | output | 16 | Pattern row byte address for entry1 |
| tag0 | output | 8 | Palette/priority tag for entry0 |
| tag1 | output | 8 | Palette/priority tag for entry1 |
| order0 | output | 24 | Pixel-to-nibble map for entry0 |
| order1 | output | 24 | Pixel-to-nibble map for entry1 |

## Verification
Column 0 is driven so that the first entry's horizontal position must wrap. A design that drops the borrow would fetch from the far end of the wrong row. Size code 2 is forced on each axis: a design that mis-decodes it would produce non-zero fine offsets or two different addresses where both entries must collapse onto the row base. Both vertical scroll modes are mixed with scroll values that differ per column, which exposes a design that reads the wrong RAM slot. Vertical flip is checked at fine offsets 0 and 7, and horizontal flip is checked field by field, so a reversed row or a mirrored pixel map shows up directly.

// File: rtl/tmag_pkg.sv
package tmag_pkg;
    localparam int ADDR_W = 16;
    localparam int SCR_W  = 10;
    localparam int ENT_W  = 16;
    localparam int PIX_N  = 8;
    localparam int ORD_W  = 3 * PIX_N;

    typedef struct packed {
        logic              nt_v;
        logic [ADDR_W-1:0] nt0;
        logic [ADDR_W-1:0] nt1;
        logic [2:0]        fine;
        logic              pat_v;
        logic [ADDR_W-1:0] pat0;
        logic [ADDR_W-1:0] pat1;
        logic [7:0]        tag0;
        logic [7:0]        tag1;
        logic [ORD_W-1:0]  ord0;
        logic [ORD_W-1:0]  ord1;
    } tmag_state_t;
endpackage

// File: rtl/tmag_vpos.sv
module tmag_vpos
    import tmag_pkg::*;
#(
    parameter int COL_W  = 6,
    parameter int LINE_W = 10
) (
    input  logic [(1<<COL_W)*SCR_W-1:0] vscroll_ram,
    input  logic [COL_W-1:0]            column,
    input  logic                        per_col,
    input  logic [LINE_W-1:0]           line_num,
    input  logic [1:0]                  vcode,
    output logic [2:0]                  fine,
    output logic [SCR_W-4:0]            trow
);
    logic [COL_W-1:0] idx;
    logic [SCR_W-1:0] vs_sel;
    logic [SCR_W-1:0] vmask;
    logic [SCR_W-1:0] vsum;
    logic [SCR_W-1:0] vval;

    always_comb begin
        idx    = per_col ? column : '0;
        vs_sel = vscroll_ram[idx*SCR_W +: SCR_W];
        vsum   = vs_sel + SCR_W'(line_num);
        unique case (vcode)
            2'd0:    vmask = 10'h0FF;
            2'd1:    vmask = 10'h1FF;
            2'd2:    vmask = 10'h000;
            default: vmask = 10'h3FF;
        endcase
        vval = vsum & vmask;
        fine = vval[2:0];
        trow = vval[SCR_W-1:3];
    end
endmodule

// File: rtl/tmag_hcol.sv
module tmag_hcol
    import tmag_pkg::*;
#(
    parameter int COL_W = 6,
    parameter int DELTA = 0
) (
    input  logic [SCR_W-1:0]  hscroll,
    input  logic [COL_W-1:0]  column,
    input  logic [1:0]        hcode,
    input  logic [SCR_W-4:0]  trow,
    input  logic [2:0]        base3,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFF_W = ADDR_W - 3;
    localparam int ROW_W = SCR_W - 3 + 8;

    logic [SCR_W-1:0] cidx;
    logic [SCR_W-1:0] cpos;
    logic [SCR_W-1:0] hmask;
    logic [SCR_W-1:0] hpos;
    logic [ROW_W-1:0] rowterm;
    logic [ROW_W-1:0] sum;

    always_comb begin
        cidx = SCR_W'(column) - SCR_W'(DELTA);
        cpos = {cidx[SCR_W-4:0], 3'b000};
        unique case (hcode)
            2'd0:    begin hmask = 10'h0F8; rowterm = ROW_W'(trow) << 6; end
            2'd1:    begin hmask = 10'h1F8; rowterm = ROW_W'(trow) << 7; end
            2'd2:    begin hmask = 10'h000; rowterm = '0;                end
            default: begin hmask = 10'h3F8; rowterm = ROW_W'(trow) << 8; end
        endcase
        hpos = (hscroll + cpos) & hmask;
        sum  = rowterm + ROW_W'(hpos[SCR_W-1:2]);
        addr = {base3, sum[OFF_W-1:0]};
    end
endmodule

// File: rtl/tmag_entry_dec.sv
module tmag_entry_dec
    import tmag_pkg::*;
(
    input  logic [ENT_W-1:0]  entry,
    input  logic [2:0]        fine,
    output logic [ADDR_W-1:0] pat_addr,
    output logic [7:0]        tag,
    output logic [ORD_W-1:0]  order
);
    logic [2:0] row;

    always_comb begin
        row      = entry[12] ? ~fine : fine;
        pat_addr = {1'b0, entry[9:0], row, 2'b00};
        tag      = {1'b0, entry[15:13], 4'b0000};
    end

    for (genvar p = 0; p < PIX_N; p++) begin : g_order
        assign order[3*p +: 3] = entry[11] ? 3'(PIX_N - 1 - p) : 3'(p);
    end
endmodule

// File: rtl/tilemap_addr_gen.sv
module tilemap_addr_gen
    import tmag_pkg::*;
#(
    parameter int COL_W  = 6,
    parameter int LINE_W = 10
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic [COL_W-1:0]                     column,
    input  logic [LINE_W-1:0]                    line_num,
    input  logic [7:0]                           plane_reg,
    input  logic [7:0]                           size_reg,
    input  logic [7:0]                           mode_reg,
    input  logic [tmag_pkg::SCR_W-1:0]           hscroll,
    input  logic [(1<<COL_W)*tmag_pkg::SCR_W-1:0] vscroll_ram,
    output logic                                 nt_valid,
    output logic [tmag_pkg::ADDR_W-1:0]          nt_addr0,
    output logic [tmag_pkg::ADDR_W-1:0]          nt_addr1,
    output logic [2:0]                           fine_row,
    input  logic                                 ent_valid,
    input  logic [tmag_pkg::ENT_W-1:0]           entry0,
    input  logic [tmag_pkg::ENT_W-1:0]           entry1,
    output logic                                 pat_valid,
    output logic [tmag_pkg::ADDR_W-1:0]          pat_addr0,
    output logic [tmag_pkg::ADDR_W-1:0]          pat_addr1,
    output logic [7:0]                           tag0,
    output logic [7:0]                           tag1,
    output logic [tmag_pkg::ORD_W-1:0]           order0,
    output logic [tmag_pkg::ORD_W-1:0]           order1
);
    localparam int N_ENT = 2;

    tmag_state_t st_d, st_q;

    logic [2:0]       fine_c;
    logic [SCR_W-4:0] trow_c;
    logic [ADDR_W-1:0] nt_c   [N_ENT];
    logic [ADDR_W-1:0] pat_c  [N_ENT];
    logic [7:0]        tag_c  [N_ENT];
    logic [ORD_W-1:0]  ord_c  [N_ENT];
    logic [ENT_W-1:0]  ent_in [N_ENT];

    assign ent_in[0] = entry0;
    assign ent_in[1] = entry1;

    tmag_vpos #(.COL_W(COL_W), .LINE_W(LINE_W)) u_vpos (
        .vscroll_ram (vscroll_ram),
        .column      (column),
        .per_col     (mode_reg[2]),
        .line_num    (line_num),
        .vcode       (size_reg[5:4]),
        .fine        (fine_c),
        .trow        (trow_c)
    );

    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        tmag_hcol #(.COL_W(COL_W), .DELTA(N_ENT - 1 - e)) u_hcol (
            .hscroll (hscroll),
            .column  (column),
            .hcode   (size_reg[1:0]),
            .trow    (trow_c),
            .base3   (plane_reg[5:3]),
            .addr    (nt_c[e])
        );
        tmag_entry_dec u_dec (
            .entry    (ent_in[e]),
            .fine     (st_q.fine),
            .pat_addr (pat_c[e]),
            .tag      (tag_c[e]),
            .order    (ord_c[e])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.nt_v  = req_valid;
        st_d.pat_v = ent_valid;
        if (req_valid) begin
            st_d.nt0  = nt_c[0];
            st_d.nt1  = nt_c[1];
            st_d.fine = fine_c;
        end
        if (ent_valid) begin
            st_d.pat0 = pat_c[0];
            st_d.pat1 = pat_c[1];
            st_d.tag0 = tag_c[0];
            st_d.tag1 = tag_c[1];
            st_d.ord0 = ord_c[0];
            st_d.ord1 = ord_c[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nt_valid  = st_q.nt_v;
    assign nt_addr0  = st_q.nt0;
    assign nt_addr1  = st_q.nt1;
    assign fine_row  = st_q.fine;
    assign pat_valid = st_q.pat_v;
    assign pat_addr0 = st_q.pat0;
    assign pat_addr1 = st_q.pat1;
    assign tag0      = st_q.tag0;
    assign tag1      = st_q.tag1;
    assign order0    = st_q.ord0;
    assign order1    = st_q.ord1;

    p_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nt_valid |-> (nt_addr0[15:13] == $past(plane_reg[5:3]))
                  && (nt_addr1[15:13] == $past(plane_reg[5:3])));

    p_vsize_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_valid && $past(size_reg[5:4]) == 2'd2) |-> (fine_row == 3'd0));

    p_hsize_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_valid && $past(size_reg[1:0]) == 2'd2) |-> (nt_addr0 == nt_addr1));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!nt_valid && $stable(nt_addr0) && $stable(nt_addr1)));

    p_vflip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> (pat_addr0[4:2] ==
            ($past(entry0[12]) ? ~$past(fine_row) : $past(fine_row))));

    p_hflip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> (order0[2:0] == ($past(entry0[11]) ? 3'd7 : 3'd0)));

    p_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pat_valid |-> (tag0[3:0] == 4'd0 && !tag0[7] && tag1[3:0] == 4'd0 && !tag1[7]));

    p_pat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ent_valid) |-> (!pat_valid && $stable(pat_addr0) && $stable(tag1)));
endmodule

// File: tb/tilemap_addr_gen_bench.sv
module tilemap_addr_gen_bench;
    localparam int COL_W = 6;
    localparam int DEPTH = 1 << COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [5:0] column = '0;
    logic [9:0] line_num = '0;
    logic [7:0] plane_reg = '0, size_reg = '0, mode_reg = '0;
    logic [9:0] hscroll = '0;
    logic [DEPTH*10-1:0] vscroll_ram = '0;
    logic nt_valid, pat_valid, ent_valid = 1'b0;
    logic [15:0] nt_addr0, nt_addr1, pat_addr0, pat_addr1;
    logic [2:0] fine_row;
    logic [15:0] entry0 = '0, entry1 = '0;
    logic [7:0] tag0, tag1;
    logic [23:0] order0, order1;

    int checks = 0;
    int fails = 0;
    int vs [DEPTH];
    int exp_fine = 0;

    always #5 clk = ~clk;

    tilemap_addr_gen u_tilemap_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .column(column),
        .line_num(line_num), .plane_reg(plane_reg), .size_reg(size_reg),
        .mode_reg(mode_reg), .hscroll(hscroll), .vscroll_ram(vscroll_ram),
        .nt_valid(nt_valid), .nt_addr0(nt_addr0), .nt_addr1(nt_addr1),
        .fine_row(fine_row), .ent_valid(ent_valid), .entry0(entry0),
        .entry1(entry1), .pat_valid(pat_valid), .pat_addr0(pat_addr0),
        .pat_addr1(pat_addr1), .tag0(tag0), .tag1(tag1),
        .order0(order0), .order1(order1)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic int vmask_f(int c);
        case (c) 0: return 'hFF; 1: return 'h1FF; 2: return 0; default: return 'h3FF; endcase
    endfunction
    function automatic int hmask_f(int c);
        case (c) 0: return 'hF8; 1: return 'h1F8; 2: return 0; default: return 'h3F8; endcase
    endfunction
    function automatic int stride_f(int c);
        case (c) 0: return 64; 1: return 128; 2: return 0; default: return 256; endcase
    endfunction

    function automatic int vval_f();
        int v = mode_reg[2] ? vs[column] : vs[0];
        return (v + int'(line_num)) & vmask_f(int'(size_reg[5:4]));
    endfunction

    function automatic int nt_f(int delta);
        int vv = vval_f();
        int hp = (int'(hscroll) + (int'(column) - delta) * 8) & hmask_f(int'(size_reg[1:0]));
        int off = ((vv / 8) * stride_f(int'(size_reg[1:0])) + hp / 4) & 'h1FFF;
        return ((int'(plane_reg) & 'h38) << 10) + off;
    endfunction

    function automatic int pat_f(int e, int f);
        int r = ((e >> 12) & 1) ? 7 - f : f;
        return ((e & 'h3FF) << 5) + 4 * r;
    endfunction

    function automatic int ord_f(int e);
        int o = 0;
        for (int p = 0; p < 8; p++)
            o |= (((e >> 11) & 1) ? 7 - p : p) << (3 * p);
        return o;
    endfunction

    task automatic load_vs();
        for (int k = 0; k < DEPTH; k++) vscroll_ram[k*10 +: 10] = 10'(vs[k]);
    endtask

    task automatic do_req(input string tagname);
        int e0, e1, ef;
        req_valid = 1'b1;
        e0 = nt_f(1); e1 = nt_f(0); ef = vval_f() & 7;
        @(negedge clk);
        req_valid = 1'b0;
        chk({"R8 nt_valid ", tagname}, 32'(nt_valid), 1);
        chk({"R2/R6/R7 nt_addr0 ", tagname}, 32'(nt_addr0), 32'(e0));
        chk({"R3/R6/R7 nt_addr1 ", tagname}, 32'(nt_addr1), 32'(e1));
        chk({"R4/R5 fine_row ", tagname}, 32'(fine_row), 32'(ef));
        exp_fine = ef;
    endtask

    task automatic do_ent(input int a, input int b, input string tagname);
        entry0 = 16'(a); entry1 = 16'(b); ent_valid = 1'b1;
        @(negedge clk);
        ent_valid = 1'b0;
        chk({"R12 pat_valid ", tagname}, 32'(pat_valid), 1);
        chk({"R9 pat_addr0 ", tagname}, 32'(pat_addr0), 32'(pat_f(a, exp_fine)));
        chk({"R9 pat_addr1 ", tagname}, 32'(pat_addr1), 32'(pat_f(b, exp_fine)));
        chk({"R11 tag0 ", tagname}, 32'(tag0), 32'((a >> 9) & 'h70));
        chk({"R11 tag1 ", tagname}, 32'(tag1), 32'((b >> 9) & 'h70));
        chk({"R10 order0 ", tagname}, 32'(order0), 32'(ord_f(a)));
        chk({"R10 order1 ", tagname}, 32'(order1), 32'(ord_f(b)));
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] h0, h1;
        void'($urandom(32'd20241));
        for (int k = 0; k < DEPTH; k++) vs[k] = int'($urandom_range(1023, 0));
        vs[0] = 5; vs[3] = 900;
        load_vs();
        repeat (3) @(negedge clk);
        chk("R1 nt_valid reset", 32'(nt_valid), 0);
        chk("R1 pat_valid reset", 32'(pat_valid), 0);
        chk("R1 nt_addr0 reset", 32'(nt_addr0), 0);
        chk("R1 pat_addr1 reset", 32'(pat_addr1), 0);
        chk("R1 order0 reset", 32'(order0), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 column 0 wrap, R3/R6 code 3
        column = 0; hscroll = 0; line_num = 10; plane_reg = 8'h28;
        size_reg = 8'h33; mode_reg = 8'h00;
        do_req("col0 wrap");
        // R3/R6 size code 2 on both axes
        column = 7; hscroll = 10'h123; size_reg = 8'h22;
        do_req("size code 2");
        // R4 per-column selection vs shared entry
        column = 3; line_num = 100; size_reg = 8'h11; mode_reg = 8'h04;
        do_req("per-column vscroll");
        mode_reg = 8'h00;
        do_req("shared vscroll");
        // R9 vflip at fine 0 and 7, R10 hflip
        vs[0] = 0; load_vs(); line_num = 8; size_reg = 8'h00;
        do_req("fine0");
        do_ent('h1155, 'h0ABC, "vflip fine0");
        line_num = 15;
        do_req("fine7");
        do_ent('h1801, 'hE3FF, "vflip+hflip fine7");

        // R8 hold: inputs change without req_valid
        h0 = nt_addr0; h1 = pat_addr0;
        column = 9; hscroll = 10'h3FF; plane_reg = 8'hFF; line_num = 77;
        entry0 = 16'hFFFF;
        @(negedge clk);
        chk("R8 nt_valid idle", 32'(nt_valid), 0);
        chk("R8 nt_addr0 held", 32'(nt_addr0), 32'(h0));
        chk("R12 pat_valid idle", 32'(pat_valid), 0);
        chk("R12 pat_addr0 held", 32'(pat_addr0), 32'(h1));

        for (int i = 0; i < 300; i++) begin
            column   = 6'($urandom_range(63, 0));
            line_num = 10'($urandom_range(1023, 0));
            plane_reg = 8'($urandom());
            size_reg  = 8'($urandom());
            mode_reg  = 8'($urandom());
            hscroll   = 10'($urandom());
            do_req("random");
            do_ent(int'($urandom_range(65535, 0)), int'($urandom_range(65535, 0)), "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule